// File: doc/BRIEF.md
# Inter-Core Doorbell Router

The router accepts doorbell commands for a small cluster of cores and keeps, for every core, a set of pending doorbell flags. A send command carries a 32-bit message word. The router decodes the message type, works out which cores the message addresses, and sets the matching pending flag on each of them. A clear command carries a message word and the index of the core that issues it. It removes the decoded flag from that core only. Setting any flag also raises the core's interrupt request line. Delivering and acknowledging the interrupt is left to logic outside this block.

A build-time parameter selects one of two flavours. The embedded flavour recognises a normal and a critical doorbell, and it can broadcast to every core. The server flavour recognises only the hypervisor doorbell, and it always addresses cores by tag compare. Message words that do not decode do nothing at all.

Message layout: bits [31:27] hold the type, bit 26 is the broadcast flag (embedded flavour only), and bits [13:0] hold the target tag.

Top module: `dbell_router`

## Requirements
- R1: In the embedded flavour (SERVER_MODE=0), a send of type 0 sets the normal flag and a send of type 1 sets the critical flag on every addressed core.
- R2: In the embedded flavour, types 2, 3 and 4 (guest doorbells), type 5 and all types from 6 to 31 change no flag, whether they arrive as a send or as a clear. The hypervisor flag is never set in this flavour.
- R3: In the embedded flavour, a send with bit 26 set addresses every core and ignores the tag. With bit 26 clear, a send addresses exactly those cores whose 14-bit ID equals bits [13:0]. More than one core may match.
- R4: In the server flavour (SERVER_MODE=1), only type 5 is valid, and it sets the hypervisor flag. Every other type is a no-op, and the normal and critical flags stay at 0.
- R5: In the server flavour, bit 26 has no effect. Targets are chosen only by comparing the tag with each core ID.
- R6: A clear decodes the type in the same way as a send. It removes only the decoded flag, and only on the core given by clr_core. The other cores and the other flags are left unchanged.
- R7: irq_req[k] is 1 exactly when core k has at least one pending flag. It therefore rises in the same cycle as the flag that causes it.
- R8: When a send and a clear in the same cycle both decode to the same flag on the same core, the flag ends up set.
- R9: Synchronous active-low reset clears every flag and every interrupt request. Flags hold their value in cycles with no command.
- R10: A command sampled at a rising clock edge is visible on the flag outputs directly after that edge. There is a single register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| snd_valid | input | 1 | Send command present this cycle |
| snd_msg | input | 32 | Send message word |
| clr_valid | input | 1 | Clear command present this cycle |
| clr_core | input | IDX_W | Index of the core issuing the clear |
| clr_msg | input | 32 | Clear message word |
| core_ids | input | NUM_CORES*TAG_W | Core ID values; core k occupies bits [k*TAG_W +: TAG_W] |
| pend_norm | output | NUM_CORES | Normal doorbell pending, one bit per core |
| pend_crit | output | NUM_CORES | Critical doorbell pending, one bit per core |
| pend_hyp | output | NUM_CORES | Hypervisor doorbell pending, one bit per core |
| irq_req | output | NUM_CORES | Interrupt request, one bit per core |

## Verification
All state in the block is the pending flags, and every flag is a port. A wrong decode, a wrong target match or a clear applied to the wrong core therefore shows on the flag outputs one edge after the command. The wrong value then stays visible until a later command overwrites it. Comparing every flag and every interrupt line with a behavioural model on every cycle catches such an error at the first cycle it occurs, in both flavours.

// File: rtl/dbell_pkg.sv
// Shared constants and types for the doorbell router.
// Assumes a 32-bit message word with a fixed field layout.
package dbell_pkg;

    localparam int MSG_W     = 32;
    localparam int TYPE_HI   = 31;
    localparam int TYPE_LO   = 27;
    localparam int TYPE_W    = TYPE_HI - TYPE_LO + 1;
    localparam int BCAST_BIT = 26;
    localparam int TAG_BITS  = 14;

    localparam logic [TYPE_W-1:0] MT_NORMAL   = 5'd0;
    localparam logic [TYPE_W-1:0] MT_CRITICAL = 5'd1;
    localparam logic [TYPE_W-1:0] MT_HYPER    = 5'd5;

    // One pending flag per doorbell class
    typedef struct packed {
        logic hyp;
        logic crit;
        logic norm;
    } pend_t;

endpackage

// File: rtl/dbell_type_decode.sv
// Maps a message type to a one-hot pending-flag selection.
// Assumes SERVER_MODE is 0 (embedded) or 1 (server); undecodable types give all zero.
module dbell_type_decode
    import dbell_pkg::*;
#(
    parameter int SERVER_MODE = 0
) (
    input  logic [TYPE_W-1:0] msg_type,
    output pend_t             sel
);

    generate
        if (SERVER_MODE != 0) begin : g_server
            // Server flavour: only the hypervisor type decodes
            always_comb begin
                sel      = '0;
                sel.hyp  = (msg_type == MT_HYPER);
            end
        end else begin : g_embedded
            // Embedded flavour: normal and critical types decode, guest types do not
            always_comb begin
                sel      = '0;
                sel.norm = (msg_type == MT_NORMAL);
                sel.crit = (msg_type == MT_CRITICAL);
            end
        end
    endgenerate

endmodule

// File: rtl/dbell_target_match.sv
// Produces the per-core hit vector of a send command.
// Assumes core IDs are packed low core first; broadcast overrides the tag compare.
module dbell_target_match #(
    parameter int NUM_CORES = 4,
    parameter int TAG_W     = 14
) (
    input  logic [TAG_W-1:0]           tag,
    input  logic                       bcast,
    input  logic [NUM_CORES*TAG_W-1:0] core_ids,
    output logic [NUM_CORES-1:0]       hits
);

    genvar k;
    generate
        for (k = 0; k < NUM_CORES; k++) begin : g_core
            // Core is addressed by broadcast or by an exact ID match
            assign hits[k] = bcast || (core_ids[k*TAG_W +: TAG_W] == tag);
        end
    endgenerate

endmodule

// File: rtl/dbell_pend_cell.sv
// Holds the pending doorbell flags of one core and drives its interrupt request.
// Assumes the set path wins over the clear path for the same flag in one cycle.
module dbell_pend_cell
    import dbell_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  set_en,
    input  pend_t set_sel,
    input  logic  clr_en,
    input  pend_t clr_sel,
    output pend_t pend,
    output logic  irq
);

    pend_t set_mask;
    pend_t clr_mask;
    pend_t pend_nxt;

    // Gate the decoded selections with their enables and apply clear before set
    always_comb begin
        set_mask = set_en ? set_sel : pend_t'('0);
        clr_mask = clr_en ? clr_sel : pend_t'('0);
        pend_nxt = (pend & ~clr_mask) | set_mask;
    end

    // Flag storage with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= pend_nxt;
    end

    // Interrupt request is raised while any flag is pending
    assign irq = |pend;

endmodule

// File: rtl/dbell_router.sv
// Doorbell router: decodes send and clear commands and keeps per-core pending flags.
// Assumes at most one send and one clear per cycle; the clear applies to clr_core only.
module dbell_router
    import dbell_pkg::*;
#(
    parameter int NUM_CORES   = 4,
    parameter int TAG_W       = TAG_BITS,
    parameter int SERVER_MODE = 0,
    parameter int IDX_W       = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       snd_valid,
    input  logic [MSG_W-1:0]           snd_msg,
    input  logic                       clr_valid,
    input  logic [IDX_W-1:0]           clr_core,
    input  logic [MSG_W-1:0]           clr_msg,
    input  logic [NUM_CORES*TAG_W-1:0] core_ids,
    output logic [NUM_CORES-1:0]       pend_norm,
    output logic [NUM_CORES-1:0]       pend_crit,
    output logic [NUM_CORES-1:0]       pend_hyp,
    output logic [NUM_CORES-1:0]       irq_req
);

    localparam bit BCAST_OK = (SERVER_MODE == 0);

    pend_t                snd_sel;
    pend_t                clr_sel;
    logic                 snd_bcast;
    logic [NUM_CORES-1:0] snd_hits;
    logic                 msg_unused;

    // Bits of the message words that carry no meaning here
    assign msg_unused = ^{snd_msg[BCAST_BIT-1:TAG_W], clr_msg[BCAST_BIT:0],
                          (BCAST_OK ? 1'b0 : snd_msg[BCAST_BIT])};

    // Broadcast flag only counts in the embedded flavour
    assign snd_bcast = BCAST_OK && snd_msg[BCAST_BIT];

    dbell_type_decode #(.SERVER_MODE(SERVER_MODE)) u_snd_dec (
        .msg_type (snd_msg[TYPE_HI:TYPE_LO]),
        .sel      (snd_sel)
    );

    dbell_type_decode #(.SERVER_MODE(SERVER_MODE)) u_clr_dec (
        .msg_type (clr_msg[TYPE_HI:TYPE_LO]),
        .sel      (clr_sel)
    );

    dbell_target_match #(.NUM_CORES(NUM_CORES), .TAG_W(TAG_W)) u_match (
        .tag      (snd_msg[TAG_W-1:0]),
        .bcast    (snd_bcast),
        .core_ids (core_ids),
        .hits     (snd_hits)
    );

    genvar k;
    generate
        for (k = 0; k < NUM_CORES; k++) begin : g_cell
            pend_t cell_pend;

            dbell_pend_cell u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .set_en  (snd_valid && snd_hits[k]),
                .set_sel (snd_sel),
                .clr_en  (clr_valid && (clr_core == IDX_W'(k))),
                .clr_sel (clr_sel),
                .pend    (cell_pend),
                .irq     (irq_req[k])
            );

            // Spread the per-core struct onto the class-wise output vectors
            assign pend_norm[k] = cell_pend.norm;
            assign pend_crit[k] = cell_pend.crit;
            assign pend_hyp[k]  = cell_pend.hyp;
        end
    endgenerate

endmodule

// File: rtl/dbell_router_chk.sv
// Port-level checker for the doorbell router, bound to every instance.
// Assumes the same parameters as the instance it is attached to.
module dbell_router_chk #(
    parameter int NUM_CORES   = 4,
    parameter int TAG_W       = 14,
    parameter int SERVER_MODE = 0,
    parameter int IDX_W       = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       snd_valid,
    input logic [31:0]                snd_msg,
    input logic                       clr_valid,
    input logic [IDX_W-1:0]           clr_core,
    input logic [31:0]                clr_msg,
    input logic [NUM_CORES*TAG_W-1:0] core_ids,
    input logic [NUM_CORES-1:0]       pend_norm,
    input logic [NUM_CORES-1:0]       pend_crit,
    input logic [NUM_CORES-1:0]       pend_hyp,
    input logic [NUM_CORES-1:0]       irq_req
);

    generate
        if (SERVER_MODE != 0) begin : g_srv
            AST_SRV_ONLY_HYP: assert property (@(posedge clk) disable iff (!rst_n)
                (pend_norm == '0) && (pend_crit == '0)); // R4
        end else begin : g_emb
            AST_EMB_NO_HYP: assert property (@(posedge clk) disable iff (!rst_n)
                pend_hyp == '0); // R2
            AST_BCAST_ALL: assert property (@(posedge clk) disable iff (!rst_n)
                snd_valid && snd_msg[26] && (snd_msg[31:27] == 5'd0) |=> (&pend_norm)); // R3
            AST_SEND_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                snd_valid && clr_valid && snd_msg[26] && (snd_msg[31:27] == 5'd1) &&
                (clr_msg[31:27] == 5'd1) |=> pend_crit[$past(clr_core)]); // R8
        end
    endgenerate

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !snd_valid && !clr_valid |=> $stable({pend_norm, pend_crit, pend_hyp})); // R9

    genvar k;
    generate
        for (k = 0; k < NUM_CORES; k++) begin : g_core
            AST_IRQ_WITH_PEND: assert property (@(posedge clk) disable iff (!rst_n)
                irq_req[k] == (pend_norm[k] || pend_crit[k] || pend_hyp[k])); // R7
            AST_CLR_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
                clr_valid && !snd_valid && (clr_core != IDX_W'(k))
                |=> $stable({pend_norm[k], pend_crit[k], pend_hyp[k]})); // R6
        end
    endgenerate

endmodule

bind dbell_router dbell_router_chk #(
    .NUM_CORES   (NUM_CORES),
    .TAG_W       (TAG_W),
    .SERVER_MODE (SERVER_MODE),
    .IDX_W       (IDX_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .snd_valid (snd_valid),
    .snd_msg   (snd_msg),
    .clr_valid (clr_valid),
    .clr_core  (clr_core),
    .clr_msg   (clr_msg),
    .core_ids  (core_ids),
    .pend_norm (pend_norm),
    .pend_crit (pend_crit),
    .pend_hyp  (pend_hyp),
    .irq_req   (irq_req)
);

// File: tb/test_dbell_router.sv
`timescale 1ns/1ps
module test_dbell_router;

    localparam int NC = 4;
    localparam int TW = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          snd_valid = 1'b0;
    logic [31:0]   snd_msg = '0;
    logic          clr_valid = 1'b0;
    logic [1:0]    clr_core = '0;
    logic [31:0]   clr_msg = '0;
    logic [NC*TW-1:0] ids;

    logic [NC-1:0] e_norm, e_crit, e_hyp, e_irq;
    logic [NC-1:0] s_norm, s_crit, s_hyp, s_irq;

    logic [NC-1:0] m_norm [2];
    logic [NC-1:0] m_crit [2];
    logic [NC-1:0] m_hyp  [2];

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 0;

    always #2.5 clk = ~clk;

    assign ids = {14'h3FFF, 14'h0021, 14'h0021, 14'h0010};

    dbell_router #(.NUM_CORES(NC), .TAG_W(TW), .SERVER_MODE(0)) i_dbell_router (
        .clk(clk), .rst_n(rst_n), .snd_valid(snd_valid), .snd_msg(snd_msg),
        .clr_valid(clr_valid), .clr_core(clr_core), .clr_msg(clr_msg), .core_ids(ids),
        .pend_norm(e_norm), .pend_crit(e_crit), .pend_hyp(e_hyp), .irq_req(e_irq)
    );

    dbell_router #(.NUM_CORES(NC), .TAG_W(TW), .SERVER_MODE(1)) i_dbell_router_srv (
        .clk(clk), .rst_n(rst_n), .snd_valid(snd_valid), .snd_msg(snd_msg),
        .clr_valid(clr_valid), .clr_core(clr_core), .clr_msg(clr_msg), .core_ids(ids),
        .pend_norm(s_norm), .pend_crit(s_crit), .pend_hyp(s_hyp), .irq_req(s_irq)
    );

    function automatic logic [31:0] mk(int t, bit bc, logic [13:0] tag);
        logic [31:0] w = '0;
        w[31:27] = t[4:0];
        w[26]    = bc;
        w[13:0]  = tag;
        return w;
    endfunction

    // Behavioural reference: apply one clock edge to both flavours
    task automatic model_edge();
        for (int m = 0; m < 2; m++) begin
            if (!rst_n) begin
                m_norm[m] = '0; m_crit[m] = '0; m_hyp[m] = '0;
            end else begin
                for (int k = 0; k < NC; k++) begin
                    int  st  = int'(snd_msg[31:27]);
                    int  ct  = int'(clr_msg[31:27]);
                    bit  hit = ((m == 0) && snd_msg[26]) || (snd_msg[13:0] == ids[k*TW +: TW]);
                    bit  sv  = snd_valid && hit;
                    bit  cv  = clr_valid && (int'(clr_core) == k);
                    if (cv && m == 0 && ct == 0) m_norm[m][k] = 1'b0;
                    if (cv && m == 0 && ct == 1) m_crit[m][k] = 1'b0;
                    if (cv && m == 1 && ct == 5) m_hyp[m][k]  = 1'b0;
                    if (sv && m == 0 && st == 0) m_norm[m][k] = 1'b1;
                    if (sv && m == 0 && st == 1) m_crit[m][k] = 1'b1;
                    if (sv && m == 1 && st == 5) m_hyp[m][k]  = 1'b1;
                end
            end
        end
    endtask

    task automatic compare(string req);
        logic [15:0] act, exp;
        for (int m = 0; m < 2; m++) begin
            exp = {m_norm[m], m_crit[m], m_hyp[m], m_norm[m] | m_crit[m] | m_hyp[m]};
            act = (m == 0) ? {e_norm, e_crit, e_hyp, e_irq} : {s_norm, s_crit, s_hyp, s_irq};
            n_checks++;
            if (act !== exp) begin
                n_fail++;
                $display("FAIL %s mode=%0d actual=%h expected=%h", req, m, act, exp);
            end
        end
    endtask

    task automatic step(string req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(req);
        snd_valid = 1'b0;
        clr_valid = 1'b0;
    endtask

    task automatic send(int t, bit bc, logic [13:0] tag, string req);
        snd_valid = 1'b1; snd_msg = mk(t, bc, tag);
        step(req);
    endtask

    task automatic clear(int t, int core, string req);
        clr_valid = 1'b1; clr_msg = mk(t, 1'b0, 14'h0); clr_core = 2'(core);
        step(req);
    endtask

    initial begin
        repeat (3) step("R9");
        rst_n = 1'b1;
        step("R9");
        send(0, 0, 14'h0010, "R1");
        send(1, 0, 14'h0021, "R3");
        send(0, 1, 14'h0999, "R3");
        send(5, 1, 14'h3FFF, "R5");
        send(5, 0, 14'h0022, "R4");
        send(2, 0, 14'h0010, "R2");
        send(3, 1, 14'h0010, "R2");
        send(4, 0, 14'h3FFF, "R2");
        send(31, 1, 14'h0021, "R2");
        send(5, 1, 14'h0010, "R5");
        clear(0, 2, "R6");
        clear(3, 0, "R2");
        clear(1, 0, "R6");
        clear(5, 3, "R6");
        send(1, 0, 14'h0010, "R1");
        // Send and clear of the same flag on core 0 in one cycle
        snd_valid = 1'b1; snd_msg = mk(1, 0, 14'h0010);
        clr_valid = 1'b1; clr_msg = mk(1, 0, 14'h0); clr_core = 2'd0;
        step("R8");
        snd_valid = 1'b1; snd_msg = mk(5, 0, 14'h0010);
        clr_valid = 1'b1; clr_msg = mk(5, 0, 14'h0); clr_core = 2'd0;
        step("R8");
        // Send to one core and clear on another in the same cycle
        snd_valid = 1'b1; snd_msg = mk(0, 0, 14'h3FFF);
        clr_valid = 1'b1; clr_msg = mk(1, 0, 14'h0); clr_core = 2'd1;
        step("R6");
        repeat (3) step("R9");
        for (int k = 0; k < NC; k++) begin
            clear(0, k, "R7");
            clear(1, k, "R7");
            clear(5, k, "R7");
        end
        send(5, 0, 14'h0021, "R10");
        send(0, 0, 14'h0021, "R10");
        rst_n = 1'b0;
        step("R9");
        rst_n = 1'b1;
        step("R9");
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R10 actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule